// File: doc/BRIEF.md
# Phase-Continuous Direct Digital Synthesizer

This block generates a digital sine-shaped waveform. A 32-bit phase accumulator adds a frequency tuning word on every clock. The upper twelve bits of the phase, offset by a programmable phase adjustment, select a point on a sine-shaped curve. That value is then scaled by an amplitude factor and registered onto the sample output, which feeds a DAC outside the block.

Software loads the three settings a byte at a time through an 8-bit parallel write port. Each setting has a shadow copy and an active copy. Writes change only the shadow copies. A single update strobe copies all of them into the active copies together. A change of frequency never reloads the accumulator, so the waveform has no phase step at the change. The amplitude factor comes out of reset at zero, so the output stays silent until software programs it. Rewriting and committing the amplitude factor repeatedly gives amplitude modulation.

Top module: `dds_core`

## Requirements
- R1: While `rst_n` is low, and after its release until something is committed, `sample_out` is 0. The accumulator and every shadow and active setting reset to zero.
- R2: On each clock the accumulator advances by the active tuning word, modulo 2^32. Committing a new tuning word never reloads or clears it, so counting continues from the current phase.
- R3: The lookup phase is p = (acc[31:20] + offset) mod 4096, where offset is the active 12-bit phase offset. The wave value is w = sign·min(2047, (x·(2048−x)) >> 9), where x = p[10:0] and the sign is negative when p[11] = 1.
- R4: The sample is (w · scale) >>> 14, an arithmetic shift that rounds toward minus infinity, with scale the active 14-bit unsigned factor. When scale is zero, every sample is 0.
- R5: Byte addresses on `wr_addr`: 0–3 hold tuning word bits [7:0], [15:8], [23:16] and [31:24]. Address 4 holds offset [7:0], and address 5 bits [3:0] hold offset [11:8]. Address 6 holds scale [7:0], and address 7 bits [5:0] hold scale [13:8]. Any other address has no effect, and a write changes only the byte it addresses.
- R6: Shadow writes leave the active settings alone. When `update` is high at a clock edge, all three active settings take the shadow values held before that edge. A write made in the same cycle goes only to the shadow.
- R7: `sample_out` is registered. The value present after edge k is computed from the accumulator and active settings as they stood just before edge k.
- R8: Committing a tuning word used earlier does not restore the phase that word had before. The phase follows from the total accumulation only.
- R9: The scale can be rewritten and committed any number of times while the accumulator runs. Each commit changes only the amplitude, from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write enable for the shadow settings |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 8 | Byte to write |
| update | input | 1 | Commit strobe, copies shadow settings to active |
| sample_out | output | 12 | Signed output sample |

## Verification
The bench runs a behavioural model alongside the design and compares every sample. It uses several tuning-word patterns: a slow one that steps through adjacent lookup points, a fast one that wraps the accumulator many times, a partial byte change, and a return to an earlier word. Comparing phase across these shows whether the accumulator is ever reloaded. Half-turn and quarter-turn offsets test that the offset is added rather than substituted. A scale sequence of zero, full scale, half and odd values tests the product truncation and the sign handling. Writes without a strobe, writes to unused addresses, and a write in the same cycle as the strobe test that the shadow and active copies stay separate.

// File: rtl/dds_core.sv
module dds_core #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 12,
  parameter int SAMP_W  = 12,
  parameter int SCALE_W = 14,
  parameter int BUS_AW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [BUS_AW-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     update,
  output logic signed [SAMP_W-1:0] sample_out
);
  localparam int FTW_BYTES = (PHASE_W + 7) / 8;
  localparam int OFF_BYTES = (ADDR_W + 7) / 8;
  localparam int OFF_BASE  = FTW_BYTES;
  localparam int SCL_BASE  = OFF_BASE + OFF_BYTES;
  localparam int PW        = 2 * ADDR_W;
  localparam int SHIFT     = 2 * (ADDR_W - 2) - (SAMP_W - 1);
  localparam int HALF      = 1 << (ADDR_W - 1);
  localparam int MAXA      = (1 << (SAMP_W - 1)) - 1;
  localparam int MW        = SAMP_W + SCALE_W + 1;

  logic [PHASE_W-1:0] acc, ftw_sh, ftw_act;
  logic [ADDR_W-1:0]  off_sh, off_act;
  logic [SCALE_W-1:0] scl_sh, scl_act;

  // R5: bit-level byte decode keeps each shadow at its exact width
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_sh <= '0;
      off_sh <= '0;
      scl_sh <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < PHASE_W; b++)
        if (wr_addr == BUS_AW'(b / 8)) ftw_sh[b] <= wr_data[b % 8];
      for (int b = 0; b < ADDR_W; b++)
        if (wr_addr == BUS_AW'(OFF_BASE + b / 8)) off_sh[b] <= wr_data[b % 8];
      for (int b = 0; b < SCALE_W; b++)
        if (wr_addr == BUS_AW'(SCL_BASE + b / 8)) scl_sh[b] <= wr_data[b % 8];
    end
  end

  // R6: one strobe commits all three settings together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_act <= '0;
      off_act <= '0;
      scl_act <= '0;
    end else if (update) begin
      ftw_act <= ftw_sh;
      off_act <= off_sh;
      scl_act <= scl_sh;
    end
  end

  // R2: the accumulator is never reloaded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc + ftw_act;
  end

  // R3: parabolic half-wave shape
  logic [ADDR_W-1:0]        phase;
  logic [ADDR_W-2:0]        x;
  logic [ADDR_W-1:0]        xc;
  logic [PW-1:0]            amp_raw;
  logic [SAMP_W-1:0]        amp;
  logic signed [SAMP_W-1:0] wave;
  logic signed [MW-1:0]     mult;

  assign phase   = acc[PHASE_W-1 -: ADDR_W] + off_act;
  assign x       = phase[ADDR_W-2:0];
  assign xc      = ADDR_W'(HALF) - {1'b0, x};
  assign amp_raw = (PW'(x) * PW'(xc)) >> SHIFT;
  assign amp     = (amp_raw > PW'(MAXA)) ? SAMP_W'(MAXA) : SAMP_W'(amp_raw);
  assign wave    = phase[ADDR_W-1] ? -$signed(amp) : $signed(amp);

  // R4: scale treated as a fraction of 2^SCALE_W, floor truncation
  assign mult = MW'(wave) * MW'($signed({1'b0, scl_act}));

  // R7: one output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_out <= '0;
    else        sample_out <= SAMP_W'(mult >>> SCALE_W);
  end
endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 12,
  parameter int SAMP_W  = 12,
  parameter int SCALE_W = 14
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     update,
  input logic signed [SAMP_W-1:0] sample_out,
  input logic [PHASE_W-1:0]       acc,
  input logic [PHASE_W-1:0]       ftw_sh,
  input logic [PHASE_W-1:0]       ftw_act,
  input logic [ADDR_W-1:0]        off_sh,
  input logic [ADDR_W-1:0]        off_act,
  input logic [SCALE_W-1:0]       scl_sh,
  input logic [SCALE_W-1:0]       scl_act
);
  AST_SILENT_AT_ZERO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_act == '0) |=> (sample_out == '0)); // R4

  AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> ($stable(ftw_act) && $stable(off_act) && $stable(scl_act))); // R6

  AST_COMMIT_FROM_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (ftw_act == $past(ftw_sh) && off_act == $past(off_sh) && scl_act == $past(scl_sh))); // R6

  AST_PHASE_FROZEN_AT_ZERO_FTW: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw_act == '0) |=> $stable(acc)); // R2

  AST_RESET_SILENT: assert property (@(posedge clk)
    !rst_n |-> (sample_out == '0 && acc == '0)); // R1
endmodule

bind dds_core dds_core_chk #(
  .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .SCALE_W(SCALE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .update(update), .sample_out(sample_out),
  .acc(acc), .ftw_sh(ftw_sh), .ftw_act(ftw_act), .off_sh(off_sh),
  .off_act(off_act), .scl_sh(scl_sh), .scl_act(scl_act)
);

// File: tb/dds_core_bench.sv
`timescale 1ns/1ps
module dds_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic update = 1'b0;
  logic signed [11:0] sample_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  dds_core u_dds_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .update(update), .sample_out(sample_out)
  );

  bit [31:0] m_acc, m_ftw, m_ftw_sh;
  int m_off, m_off_sh, m_scl, m_scl_sh, m_exp;

  function automatic int wave_of(int p);
    int x, y;
    x = p & 2047;
    y = (x * (2048 - x)) >> 9;
    if (y > 2047) y = 2047;
    return ((p >> 11) & 1) ? -y : y;
  endfunction

  function automatic int sample_of(bit [31:0] a, int off, int scl);
    int p, w;
    p = (int'(a >> 20) + off) & 4095;
    w = wave_of(p);
    return (w * scl) >>> 14;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_ftw = 0; m_ftw_sh = 0;
      m_off = 0; m_off_sh = 0; m_scl = 0; m_scl_sh = 0; m_exp = 0;
    end else begin
      m_exp = sample_of(m_acc, m_off, m_scl);
      m_acc = m_acc + m_ftw;
      if (update) begin
        m_ftw = m_ftw_sh; m_off = m_off_sh; m_scl = m_scl_sh;
      end
      if (wr_en) begin
        case (wr_addr)
          4'd0, 4'd1, 4'd2, 4'd3: m_ftw_sh[wr_addr*8 +: 8] = wr_data;
          4'd4: m_off_sh = (m_off_sh & 'hF00) | int'(wr_data);
          4'd5: m_off_sh = (m_off_sh & 'h0FF) | ((int'(wr_data) & 'hF) << 8);
          4'd6: m_scl_sh = (m_scl_sh & 'h3F00) | int'(wr_data);
          4'd7: m_scl_sh = (m_scl_sh & 'h00FF) | ((int'(wr_data) & 'h3F) << 8);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: sample_out=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) check(cur_req, int'(sample_out), m_exp);
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic commit();
    update = 1'b1; tick(); update = 1'b0;
  endtask

  task automatic set_ftw(bit [31:0] f);
    for (int i = 0; i < 4; i++) wr(i, f[i*8 +: 8]);
  endtask

  initial begin
    cur_req = "R1";
    #55;
    check("R1", int'(sample_out), 0);
    rst_n = 1'b1;
    tick(5);
    check("R1", int'(sample_out), 0);

    cur_req = "R4";
    set_ftw(32'h0100_0000);
    commit();
    tick(40);
    check("R4", int'(sample_out), 0);

    cur_req = "R3";
    wr(6, 8'hFF); wr(7, 8'h3F);
    commit();
    tick(300);
    set_ftw(32'h00A3_D70A);
    commit();
    tick(300);

    cur_req = "R6";
    set_ftw(32'h0733_1000);
    wr(6, 8'h00); wr(7, 8'h20);
    tick(25);
    update = 1'b1; wr_en = 1'b1; wr_addr = 4'd7; wr_data = 8'h10;
    tick();
    update = 1'b0; wr_en = 1'b0;
    tick(30);
    commit();
    tick(30);

    cur_req = "R5";
    wr(2, 8'h5A);
    commit();
    tick(30);
    wr(9, 8'hAA); wr(15, 8'h55); wr(12, 8'hFF);
    commit();
    tick(30);
    wr(5, 8'hF8); wr(7, 8'hFF);
    commit();
    tick(30);

    cur_req = "R3";
    wr(4, 8'h00); wr(5, 8'h08);
    commit();
    tick(40);
    wr(5, 8'h04);
    commit();
    tick(40);
    wr(5, 8'h00);
    commit();

    cur_req = "R2";
    set_ftw(32'hF123_4567);
    commit();
    tick(200);
    set_ftw(32'h0002_0000);
    commit();
    tick(100);

    cur_req = "R8";
    set_ftw(32'h0123_4567);
    commit();
    tick(37);
    set_ftw(32'h0345_6789);
    commit();
    tick(23);
    set_ftw(32'h0123_4567);
    commit();
    tick(60);

    cur_req = "R9";
    for (int k = 0; k < 24; k++) begin
      int s;
      s = (k * 1337 + 17) & 16'h3FFF;
      if (k == 5) s = 0;
      if (k == 9) s = 16'h2000;
      wr(6, s & 8'hFF);
      wr(7, s >> 8);
      commit();
      tick(5);
    end

    cur_req = "R7";
    set_ftw(32'h1000_0000);
    commit();
    tick(20);

    cur_req = "R4";
    wr(6, 0); wr(7, 0);
    commit();
    tick(3);
    check("R4", int'(sample_out), 0);
    tick(20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule